// File: doc/BRIEF.md
# Halftone and Binarization Unit

This block turns a stream of 7-bit grey pixels into 1-bit black/white pixels for a facsimile transmitter. Every pixel first passes through a loadable 128-entry lookup table that maps the 7-bit input to a 6-bit level. The 6-bit level then goes through one of three binarizers, chosen at run time:
- a fixed slice against a 5-bit threshold;
- an ordered dither with one of three matrices: a clustered 4x4 mesh, a clustered 8x8 mesh, or a dispersed 4x4 Bayer pattern;
- Floyd-Steinberg error diffusion at 64 levels. It carries quantization error to the right along the line and down into the next line through a built-in one-line buffer.

Pixels arrive with valid, page-start, line-start and line-end markers. A small register port sets the mode and the threshold and loads the table. The output is one bit per pixel, high for white, with the line markers carried alongside it. Input code 0x7F is white and 0x00 is black. Every line of a page must have the same length, no longer than `MAX_LINE`. The page-start marker is only given together with a line-start marker.

Top module: `halftone_bin`

## Requirements
- R1: After reset the table holds the identity mapping: level = input code >> 1 (0x7F gives level 63, 0x00 gives level 0).
- R2: Register 2 sets the table pointer. Each write to register 3 stores its low 6 bits at the pointer, then increments the pointer.
- R3: A register write is ignored while a pixel is presented, while a line is open (from an accepted line-start to its line-end), or while a pixel is in the first pipeline stage. This covers the mode, the threshold, the table pointer and table entries.
- R4: In slice mode (register 0 code 0, the reset mode) a pixel is white when (level >> 1) >= threshold. The threshold is register 1, bits 4:0, and resets to 16.
- R5: Code 3 selects the 4x4 Bayer dither. With x = column mod 4 and y = row mod 4, the rank is m = {(x^y)[0], y[0], (x^y)[1], y[1]}. The pixel is white when level >= 4*m + 2.
- R6: Code 1 selects the 4x4 mesh dither. Its ranks, row by row from row 0 and in column order, are 12 5 6 13 / 4 0 1 7 / 11 3 2 8 / 15 10 9 14. The pixel is white when level >= 4*m + 2.
- R7: Code 2 selects the 8x8 mesh. The rank is m = 4*mesh4(x mod 4, y mod 4) + 2*((x/4 ^ y/4) mod 2) + (y/4 mod 2), with x and y taken mod 8. The pixel is white when level > m.
- R8: The column count restarts at 0 on each line start. The row count restarts at 0 on page start and advances after each line end.
- R9: Code 4 selects error diffusion. Let s = 16*level + 7*e(left) + 3*e(above-right) + 5*e(above) + 1*e(above-left). Let v = floor(s/16). The pixel is white when v >= 32. Its error is v-63 when white and v when black, clipped to at most 31. Errors outside the line count as 0.
- R10: In error diffusion, errors from the line above are taken as 0 on the first line of each page. This holds whatever the previous page left behind.
- R11: Each output appears exactly two clock cycles after its input pixel, in every mode. The line-start and line-end outputs go with it.
- R12: While reset is asserted, out_valid_o is low.
- R13: Register 0 codes 5, 6 and 7 select slice mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 mode, 1 threshold, 2 table pointer, 3 table data |
| cfg_wdata_i | input | 7 | Register write data |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_sop_i | input | 1 | First pixel of a page |
| pix_sol_i | input | 1 | First pixel of a line |
| pix_eol_i | input | 1 | Last pixel of a line |
| pix_data_i | input | 7 | Grey input code, 0x7F white |
| out_valid_o | output | 1 | Output pixel valid |
| out_white_o | output | 1 | 1 white, 0 black |
| out_sol_o | output | 1 | Output is first of a line |
| out_eol_o | output | 1 | Output is last of a line |

## Verification
The hardest states to reach from the ports are the error-diffusion ones. The first is a stale error line left in the buffer from a previous page. The second is error state that must survive gaps in the pixel stream. To reach the first, the bench runs one diffusion page and then starts a fresh page over the same buffer. To reach the second, the first page has idle cycles inside lines. Both are compared against a bench-side Floyd-Steinberg model. The register lock is exercised by opening a line, then writing mode, threshold and table data between pixels before closing it. Afterwards the bench probes for pixels whose colour would reveal any of those writes.

// File: rtl/halftone_pkg.sv
package halftone_pkg;
  localparam int unsigned PIX_W = 7;
  localparam int unsigned LVL_W = 6;
  localparam int unsigned THR_W = 5;
  localparam int unsigned ERR_W = 6;
  localparam int unsigned ACC_W = 10;
  localparam int unsigned SUM_W = 12;

  typedef enum logic [2:0] {
    MODE_SLICE   = 3'd0,
    MODE_MESH4   = 3'd1,
    MODE_MESH8   = 3'd2,
    MODE_BAYER4  = 3'd3,
    MODE_DIFFUSE = 3'd4
  } ht_mode_e;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_THR   = 2'd1,
    REG_GADDR = 2'd2,
    REG_GDATA = 2'd3
  } ht_reg_e;

  function automatic ht_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return MODE_MESH4;
      3'd2:    return MODE_MESH8;
      3'd3:    return MODE_BAYER4;
      3'd4:    return MODE_DIFFUSE;
      default: return MODE_SLICE;
    endcase
  endfunction
endpackage

// File: rtl/ht_cfg_regs.sv
module ht_cfg_regs
  import halftone_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  logic             lock_i,
  output ht_mode_e         mode_o,
  output logic [THR_W-1:0] thr_o,
  output logic             lut_we_o,
  output logic [PIX_W-1:0] lut_addr_o,
  output logic [LVL_W-1:0] lut_data_o
);
  logic wr;
  assign wr = we_i & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= MODE_SLICE;
      thr_o      <= THR_W'(16);
      lut_addr_o <= '0;
    end else if (wr) begin
      case (ht_reg_e'(addr_i))
        REG_MODE:  mode_o     <= decode_mode(wdata_i[2:0]);
        REG_THR:   thr_o      <= wdata_i[THR_W-1:0];
        REG_GADDR: lut_addr_o <= wdata_i;
        REG_GDATA: lut_addr_o <= lut_addr_o + 1'b1;
        default: ;
      endcase
    end
  end

  assign lut_we_o   = wr && (ht_reg_e'(addr_i) == REG_GDATA);
  assign lut_data_o = wdata_i[LVL_W-1:0];
endmodule

// File: rtl/ht_gamma_lut.sv
module ht_gamma_lut
  import halftone_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PIX_W-1:0] waddr_i,
  input  logic [LVL_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic [PIX_W-1:0] raddr_i,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int unsigned DEPTH = 1 << PIX_W;
  localparam int unsigned SHIFT = PIX_W - LVL_W;

  logic [LVL_W-1:0] tbl_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= LVL_W'(i >> SHIFT);
    end else if (we_i) begin
      tbl_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lvl_o <= '0;
    else if (re_i) lvl_o <= tbl_q[raddr_i];
  end
endmodule

// File: rtl/ht_ctx.sv
module ht_ctx #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned ROW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sop_i,
  input  logic             sol_i,
  input  logic             eol_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             first_o,
  output logic             in_line_o
);
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             first_q;

  assign col_o   = sol_i ? '0 : col_q;
  assign row_o   = sop_i ? '0 : row_q;
  assign first_o = sop_i | first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q     <= '0;
      row_q     <= '0;
      first_q   <= 1'b1;
      in_line_o <= 1'b0;
    end else if (valid_i) begin
      col_q     <= col_o + 1'b1;
      row_q     <= eol_i ? row_o + 1'b1 : row_o;
      first_q   <= eol_i ? 1'b0 : first_o;
      in_line_o <= ~eol_i;
    end
  end
endmodule

// File: rtl/ht_dither.sv
module ht_dither
  import halftone_pkg::*;
(
  input  ht_mode_e         mode_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [2:0]       x_i,
  input  logic [2:0]       y_i,
  output logic             white_o
);
  // clustered 4x4 ranks, index = row*4 + column
  localparam logic [3:0] MESH4 [16] = '{
    4'd12, 4'd5,  4'd6,  4'd13,
    4'd4,  4'd0,  4'd1,  4'd7,
    4'd11, 4'd3,  4'd2,  4'd8,
    4'd15, 4'd10, 4'd9,  4'd14
  };

  logic [1:0] xy;
  logic [3:0] m_bayer, m_mesh4;
  logic [5:0] m_mesh8;

  always_comb begin
    xy      = x_i[1:0] ^ y_i[1:0];
    m_bayer = {xy[0], y_i[0], xy[1], y_i[1]};
    m_mesh4 = MESH4[{y_i[1:0], x_i[1:0]}];
    m_mesh8 = {m_mesh4, x_i[2] ^ y_i[2], y_i[2]};
    case (mode_i)
      MODE_MESH4:  white_o = lvl_i >= {m_mesh4, 2'b10};
      MODE_BAYER4: white_o = lvl_i >= {m_bayer, 2'b10};
      MODE_MESH8:  white_o = lvl_i > m_mesh8;
      default:     white_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ht_err_diff.sv
module ht_err_diff
  import halftone_pkg::*;
#(
  parameter int unsigned MAX_LINE = 256,
  parameter int unsigned COL_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sol_i,
  input  logic             eol_i,
  input  logic             first_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             white_o
);
  localparam int unsigned V_W    = SUM_W - 4;
  localparam logic [SUM_W-1:0] HALF = SUM_W'((1 << (LVL_W - 1)) << 4);
  localparam logic [V_W-1:0]   QMAX = V_W'((1 << LVL_W) - 1);
  localparam logic [V_W-1:0]   EOVR = V_W'(1 << (ERR_W - 1));

  // next-line error sums, in 16ths
  logic [ACC_W-1:0] line_q [MAX_LINE];
  logic [ERR_W-1:0] eprev_q;
  logic [ACC_W-1:0] acc_c_q, acc_n_q;

  logic [ERR_W-1:0] e_in, e_new;
  logic [ACC_W-1:0] ac, an, below, e_x, e3, e5;
  logic [SUM_W-1:0] e_in_x, sum;
  logic [V_W-1:0]   diff;

  always_comb begin
    e_in    = sol_i ? '0 : eprev_q;
    ac      = sol_i ? '0 : acc_c_q;
    an      = sol_i ? '0 : acc_n_q;
    below   = first_i ? '0 : line_q[col_i];
    e_in_x  = {{(SUM_W-ERR_W){e_in[ERR_W-1]}}, e_in};
    sum     = {{(SUM_W-LVL_W-4){1'b0}}, lvl_i, 4'b0000}
            + (e_in_x << 3) - e_in_x
            + {{(SUM_W-ACC_W){below[ACC_W-1]}}, below};
    white_o = !sum[SUM_W-1] && (sum >= HALF);
    diff    = sum[SUM_W-1:4] - (white_o ? QMAX : '0);
    e_new   = (diff == EOVR) ? ERR_W'((1 << (ERR_W - 1)) - 1) : diff[ERR_W-1:0];
    e_x     = {{(ACC_W-ERR_W){e_new[ERR_W-1]}}, e_new};
    e3      = (e_x << 1) + e_x;
    e5      = (e_x << 2) + e_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eprev_q <= '0;
      acc_c_q <= '0;
      acc_n_q <= '0;
    end else if (en_i) begin
      eprev_q <= e_new;
      acc_n_q <= ac + e5;
      acc_c_q <= e_x;
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && col_i != '0) line_q[col_i - 1'b1] <= an + e3;
    if (en_i && eol_i)       line_q[col_i]        <= ac + e5;
  end
endmodule

// File: rtl/halftone_bin.sv
module halftone_bin
  import halftone_pkg::*;
#(
  parameter int unsigned MAX_LINE = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [PIX_W-1:0] cfg_wdata_i,
  input  logic             pix_valid_i,
  input  logic             pix_sop_i,
  input  logic             pix_sol_i,
  input  logic             pix_eol_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             out_valid_o,
  output logic             out_white_o,
  output logic             out_sol_o,
  output logic             out_eol_o
);
  localparam int unsigned COL_W = (MAX_LINE > 8) ? $clog2(MAX_LINE) : 3;
  localparam int unsigned ROW_W = 3;

  ht_mode_e         mode_q;
  logic [THR_W-1:0] thr_q;
  logic             lut_we, in_line, lock;
  logic [PIX_W-1:0] lut_addr;
  logic [LVL_W-1:0] lut_data, s1_lvl;
  logic [COL_W-1:0] col, s1_col_q;
  logic [ROW_W-1:0] row, s1_row_q;
  logic             first, s1_first_q, s1_valid_q, s1_sol_q, s1_eol_q;
  logic             slice_white, dith_white, ed_white, sel_white;

  assign lock = pix_valid_i | in_line | s1_valid_q;

  ht_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .lock_i(lock),
    .mode_o(mode_q), .thr_o(thr_q),
    .lut_we_o(lut_we), .lut_addr_o(lut_addr), .lut_data_o(lut_data)
  );

  ht_gamma_lut u_lut (
    .clk_i, .rst_ni,
    .we_i(lut_we), .waddr_i(lut_addr), .wdata_i(lut_data),
    .re_i(pix_valid_i), .raddr_i(pix_data_i), .lvl_o(s1_lvl)
  );

  ht_ctx #(.COL_W(COL_W), .ROW_W(ROW_W)) u_ctx (
    .clk_i, .rst_ni,
    .valid_i(pix_valid_i), .sop_i(pix_sop_i), .sol_i(pix_sol_i), .eol_i(pix_eol_i),
    .col_o(col), .row_o(row), .first_o(first), .in_line_o(in_line)
  );

  // stage 1: table lookup and position
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_sol_q   <= 1'b0;
      s1_eol_q   <= 1'b0;
      s1_first_q <= 1'b0;
      s1_col_q   <= '0;
      s1_row_q   <= '0;
    end else begin
      s1_valid_q <= pix_valid_i;
      if (pix_valid_i) begin
        s1_sol_q   <= pix_sol_i;
        s1_eol_q   <= pix_eol_i;
        s1_first_q <= first;
        s1_col_q   <= col;
        s1_row_q   <= row;
      end
    end
  end

  assign slice_white = s1_lvl[LVL_W-1:1] >= thr_q;

  ht_dither u_dith (
    .mode_i(mode_q), .lvl_i(s1_lvl), .x_i(s1_col_q[2:0]), .y_i(s1_row_q), .white_o(dith_white)
  );

  ht_err_diff #(.MAX_LINE(MAX_LINE), .COL_W(COL_W)) u_ed (
    .clk_i, .rst_ni,
    .en_i(s1_valid_q && mode_q == MODE_DIFFUSE),
    .sol_i(s1_sol_q), .eol_i(s1_eol_q), .first_i(s1_first_q),
    .col_i(s1_col_q), .lvl_i(s1_lvl), .white_o(ed_white)
  );

  always_comb begin
    case (mode_q)
      MODE_MESH4, MODE_MESH8, MODE_BAYER4: sel_white = dith_white;
      MODE_DIFFUSE:                        sel_white = ed_white;
      default:                             sel_white = slice_white;
    endcase
  end

  // stage 2: decision register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_white_o <= 1'b0;
      out_sol_o   <= 1'b0;
      out_eol_o   <= 1'b0;
    end else begin
      out_valid_o <= s1_valid_q;
      out_sol_o   <= s1_valid_q & s1_sol_q;
      out_eol_o   <= s1_valid_q & s1_eol_q;
      if (s1_valid_q) out_white_o <= sel_white;
    end
  end
endmodule

// File: rtl/halftone_bin_chk.sv
module halftone_bin_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic       pix_valid_i,
  input logic       pix_sol_i,
  input logic       pix_eol_i,
  input logic       in_line_i,
  input logic [2:0] mode_i,
  input logic [4:0] thr_i,
  input logic       out_valid_o,
  input logic       out_sol_o,
  input logic       out_eol_o
);
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(pix_valid_i, 2)); // R11
  AST_SOL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_sol_o == $past(pix_sol_i, 2))); // R11
  AST_EOL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_eol_o == $past(pix_eol_i, 2))); // R11
  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (pix_valid_i || in_line_i)) |=> ($stable(mode_i) && $stable(thr_i))); // R3
  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o); // R12
endmodule

bind halftone_bin halftone_bin_chk u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .pix_valid_i, .pix_sol_i, .pix_eol_i,
  .in_line_i(in_line), .mode_i(mode_q), .thr_i(thr_q),
  .out_valid_o, .out_sol_o, .out_eol_o
);

// File: tb/halftone_bin_test.sv
module halftone_bin_test;
  localparam int MAXL = 256;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_addr_i = '0;
  logic [6:0] cfg_wdata_i = '0;
  logic       pix_valid_i = 1'b0, pix_sop_i = 1'b0, pix_sol_i = 1'b0, pix_eol_i = 1'b0;
  logic [6:0] pix_data_i = '0;
  logic       out_valid_o, out_white_o, out_sol_o, out_eol_o;

  halftone_bin #(.MAX_LINE(MAXL)) uut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;
  int gm [128];
  int thr_m = 16;
  bit cap_w [256];
  bit cap_s [256];
  int cap_n = 0;

  // {threshold, input code, expected white}
  localparam logic [12:0] SLICE_VEC [9] = '{
    {5'd16, 7'h7F, 1'b1}, {5'd16, 7'h00, 1'b0}, {5'd16, 7'h40, 1'b1},
    {5'd16, 7'h3F, 1'b0}, {5'd0,  7'h00, 1'b1}, {5'd31, 7'h7F, 1'b1},
    {5'd31, 7'h7B, 1'b0}, {5'd5,  7'h14, 1'b1}, {5'd5,  7'h13, 1'b0}
  };
  localparam int MESH4 [16] = '{12,5,6,13, 4,0,1,7, 11,3,2,8, 15,10,9,14};

  always @(negedge clk_i)
    if (rst_ni && out_valid_o && cap_n < 256) begin
      cap_w[cap_n] = out_white_o;
      cap_s[cap_n] = out_sol_o;
      cap_n++;
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      pix_valid_i = 0; pix_sop_i = 0; pix_sol_i = 0; pix_eol_i = 0;
    end
  endtask

  task automatic drive(input int d, input bit sop, input bit sol, input bit eol);
    @(negedge clk_i);
    pix_valid_i = 1; pix_data_i = 7'(d);
    pix_sop_i = sop; pix_sol_i = sol; pix_eol_i = eol;
  endtask

  task automatic cfg(input int a, input int d);
    @(negedge clk_i);
    pix_valid_i = 0;
    cfg_we_i = 1; cfg_addr_i = 2'(a); cfg_wdata_i = 7'(d);
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  function automatic bit ref_bit(input int mode, input int lvl, input int x, input int y);
    int m;
    case (mode)
      1: begin m = MESH4[(y%4)*4 + x%4]; return lvl >= 4*m + 2; end
      2: begin
        m = 4*MESH4[(y%4)*4 + x%4] + 2*(((x%8)/4 ^ (y%8)/4) & 1) + ((y%8)/4 & 1);
        return lvl > m;
      end
      3: begin
        m = (((x^y)&1) << 3) | ((y&1) << 2) | ((((x^y)>>1)&1) << 1) | ((y>>1)&1);
        return lvl >= 4*m + 2;
      end
      default: return (lvl >> 1) >= thr_m;
    endcase
  endfunction

  // one single-pixel line, result compared
  task automatic one_pixel(input int p, input bit exp, input string tag);
    cap_n = 0;
    drive(p, 1, 1, 1);
    idle(4);
    check(cap_n == 1 && cap_w[0] == exp, tag, cap_w[0], exp);
  endtask

  task automatic run_page(input int mode, input int nl, input int len, input int seed,
                          input bit gaps, input string tag);
    bit exp_w [256];
    int prv [MAXL + 2];
    int cur [MAXL + 2];
    int n = 0;
    idle(2);
    cap_n = 0;
    for (int i = 0; i < MAXL + 2; i++) begin prv[i] = 0; cur[i] = 0; end
    for (int y = 0; y < nl; y++) begin
      for (int x = 0; x < len; x++) begin
        int p = (x*37 + y*53 + seed*29 + ((x*y) % 7) * 5) % 128;
        int lvl = gm[p];
        bit w;
        if (mode == 4) begin
          // arrays shifted by one so index 0 and len+1 stay zero
          int corr = 7*cur[x] + ((y > 0) ? (3*prv[x+2] + 5*prv[x+1] + prv[x]) : 0);
          int v = (16*lvl + corr) >>> 4;
          int e;
          w = (v >= 32);
          e = w ? v - 63 : v;
          if (e > 31) e = 31;
          cur[x+1] = e;
        end else begin
          w = ref_bit(mode, lvl, x, y);
        end
        exp_w[n++] = w;
        drive(p, (y == 0) && (x == 0), x == 0, x == len - 1);
        if (gaps && (x % 3 == 1)) idle(1);
      end
      idle(2);
      for (int i = 0; i < MAXL + 2; i++) begin
        prv[i] = (i >= 1 && i <= len) ? cur[i] : 0;
        cur[i] = 0;
      end
    end
    idle(4);
    check(cap_n == n, {tag, " count"}, cap_n, n);
    for (int i = 0; i < n; i++) begin
      check(cap_w[i] == exp_w[i], tag, cap_w[i], exp_w[i]);
      check(cap_s[i] == (i % len == 0), "R11 sol", cap_s[i], i % len == 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) gm[i] = i >> 1;
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 0, "R12 reset valid", out_valid_o, 0);
    rst_ni = 1;
    idle(2);
    check(out_valid_o == 0, "R12 after reset", out_valid_o, 0);

    // R11: fixed two-cycle latency with markers
    drive(7'h7F, 1, 1, 1);
    @(negedge clk_i);
    pix_valid_i = 0; pix_sop_i = 0; pix_sol_i = 0; pix_eol_i = 0;
    check(out_valid_o == 0, "R11 one cycle", out_valid_o, 0);
    @(negedge clk_i);
    check(out_valid_o == 1, "R11 two cycles", out_valid_o, 1);
    check(out_sol_o == 1 && out_eol_o == 1, "R11 markers", {out_sol_o, out_eol_o}, 3);
    idle(3);

    // R1 R4: slice vectors with reset table
    foreach (SLICE_VEC[i]) begin
      thr_m = int'(SLICE_VEC[i][12:8]);
      cfg(1, thr_m);
      one_pixel(int'(SLICE_VEC[i][7:1]), SLICE_VEC[i][0], "R4 R1 slice");
    end
    thr_m = 16;
    cfg(1, 16);

    // R2: pointer then two data writes with increment
    cfg(2, 7'h50); cfg(3, 0); cfg(3, 0);
    gm[8'h50] = 0; gm[8'h51] = 0;
    one_pixel(7'h50, 0, "R2 entry 0x50");
    one_pixel(7'h51, 0, "R2 entry 0x51");
    one_pixel(7'h52, 1, "R2 entry 0x52 untouched");
    cfg(2, 7'h50); cfg(3, 40); cfg(3, 40);
    gm[8'h50] = 40; gm[8'h51] = 40;
    one_pixel(7'h51, 1, "R2 restore");

    // R3: writes while a line is open are dropped
    cap_n = 0;
    drive(7'h5A, 1, 1, 0);
    idle(3);
    cfg(0, 1); cfg(1, 0); cfg(2, 7'h5A); cfg(3, 0);
    drive(7'h20, 0, 0, 1);
    idle(4);
    check(cap_n == 2 && cap_w[0] == 1 && cap_w[1] == 0, "R3 line itself", cap_n, 2);
    one_pixel(7'h5A, 1, "R3 mode and table kept");
    one_pixel(7'h20, 0, "R3 threshold kept");

    // R13: spare codes select slice
    cfg(0, 7);
    one_pixel(7'h5A, 1, "R13 code 7");
    cfg(0, 5);
    one_pixel(7'h20, 0, "R13 code 5");

    // R5 R6 R7 R8: dither pages, second page checks row restart
    cfg(0, 1);
    run_page(1, 9, 10, 1, 0, "R6 mesh4");
    run_page(1, 5, 10, 2, 0, "R8 mesh4 page restart");
    cfg(0, 2);
    run_page(2, 9, 11, 3, 1, "R7 mesh8");
    run_page(2, 5, 11, 4, 0, "R8 mesh8 page restart");
    cfg(0, 3);
    run_page(3, 9, 10, 5, 0, "R5 bayer4");
    run_page(3, 5, 10, 6, 0, "R8 bayer4 page restart");

    // R9 R10: error diffusion with gaps, then a fresh page over stale buffer
    cfg(0, 4);
    run_page(4, 6, 12, 7, 1, "R9 diffusion");
    run_page(4, 4, 12, 8, 0, "R10 diffusion new page");
    run_page(4, 3, 12, 9, 1, "R10 diffusion second restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule